// File: doc/BRIEF.md
# ADPCM Nibble Playback Sequencer

This block reads packed 4-bit ADPCM codes out of a shared byte-wide sample memory and hands them, one per sample period, to a downstream decoder. A two-stage divider paces the sample period: a fixed prescaler followed by a programmable stage. Each memory byte carries two codes. The block walks a play pointer through memory and counts down a remaining length. It also raises sticky half-played and fully-played flags that a host turns into interrupts.

The host controls playback with a four-bit command word and three one-cycle strobes. The command word can start playback from a given pointer with a given length. It also selects repeat mode, stops automatically at the end, suppresses end detection, and acknowledges the flags. The strobes stop, pause and resume playback. The half-point rule depends on the programmed length. A repeating buffer whose length lies in the 0x8000..0x80FF window steps by 0x85 bytes. A short buffer steps by its length minus 1024. Any other buffer flags at the fixed addresses 0x0000 and 0x8000.

Top module: `adpcm_nibble_player`

## Requirements
- R1: The sample period is 6 × (16 − div_sel) clock cycles: one code_vld pulse per period while playing.
- R2: Each byte gives its high nibble first and then its low nibble on `code`. The byte is the one at `mem_addr`. `mem_addr` then moves up by one after the low nibble.
- R3: A command write with cmd_flags[2] set starts playback. It loads the pointer from rd_ptr and the length from play_len, clears both flags, and sets play_sts=1 and stop_sts=0. A command write with cmd_flags[2] clear starts nothing.
- R4: A length of L plays L+1 bytes. At the end (cmd_flags[0] clear in the stored command), full_flag goes to 1, half_flag goes to 0, and the pointer stays put. If the stored cmd_flags[2] is still set, playback stops.
- R5: While the stored cmd_flags[0] is set, end detection is off. The length stays at zero instead of wrapping, and the pointer keeps advancing.
- R6: When play_len is below 0x7FFF and the mode is not the repeat window, the first half address is rd_ptr + (play_len+1)/2. Reaching it sets half_flag and clears full_flag. The half address then moves on by play_len − 1024.
- R7: With repeat (cmd_flags[1]) set and play_len in 0x8000..0x80FF, the first half address is rd_ptr + 0x85, and each later one is 0x85 further on.
- R8: For any other length, half_flag is set when the pointer reaches 0x0000 or 0x8000.
- R9: stop_req ends playback (play_sts=0, stop_sts=1). Both stop_req and pause_req clear the stored start and repeat bits, so a paused-then-resumed playback does not stop at its end.
- R10: pause_req freezes the pointer and suppresses codes, with play_sts=0. resume_req continues with the next nibble and restores play_sts. resume_req has no effect once playback has stopped.
- R11: code_vld is high for exactly one clock per code. Sample periods that fall while stopped or paused emit nothing.
- R12: After reset, play_sts=0, stop_sts=1, both flags are 0, code_vld=0 and mem_addr=0. A command write with cmd_flags[3] set clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 4 | Programmable divider setting D |
| cmd_we | input | 1 | Command write strobe |
| cmd_flags | input | 4 | [3] flag acknowledge, [2] start / stop at end, [1] repeat, [0] hold length |
| rd_ptr | input | 16 | Start address loaded on start |
| play_len | input | 16 | Length loaded on start |
| stop_req | input | 1 | Stop strobe |
| pause_req | input | 1 | Pause strobe |
| resume_req | input | 1 | Resume strobe |
| mem_addr | output | 16 | Sample memory read address (play pointer) |
| mem_data | input | 8 | Sample memory data for mem_addr, same cycle |
| code | output | 4 | Current ADPCM code |
| code_vld | output | 1 | One-clock strobe qualifying code |
| half_flag | output | 1 | Half-played flag (sticky) |
| full_flag | output | 1 | Fully-played flag (sticky) |
| play_sts | output | 1 | Playing and not paused |
| stop_sts | output | 1 | Complement of play_sts |

## Verification
The assertions take three things for granted about the inputs. mem_data must reflect mem_addr within the same cycle. The control strobes are single-cycle pulses. div_sel stays steady while playback runs. When a strobe lands on a sample period, the strobe wins and that period is dropped, and the properties are written with that priority in mind. The stimulus feeds memory from a combinational function of the address and drives at most one strobe per cycle. It changes the divider only while the block is stopped, and it mixes random pause, resume and acknowledge traffic with directed runs through each half-point mode.

// File: rtl/adpcm_seq_pkg.sv
package adpcm_seq_pkg;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam logic [AW-1:0] BAND_STEP = 16'h0085;
  localparam logic [LW-1:0] SHORT_LIMIT = 16'h7FFF;
  localparam logic [LW-1:0] SHORT_BIAS = 16'd1024;

  typedef enum logic [1:0] {HM_BAND, HM_SHORT, HM_FIXED} half_mode_e;

  // lengths 0x8000..0x80FF form the special window
  function automatic logic in_band(input logic [LW-1:0] l);
    return l[LW-1:8] == 8'h80;
  endfunction

  function automatic half_mode_e half_mode(input logic [LW-1:0] l, input logic rep);
    if (rep && in_band(l)) return HM_BAND;
    else if (l < SHORT_LIMIT) return HM_SHORT;
    else return HM_FIXED;
  endfunction

  // (l+1)/2 written as l/2 plus the dropped low bit
  function automatic logic [AW-1:0] first_half(input logic [AW-1:0] rp, input logic [LW-1:0] l);
    if (in_band(l)) return rp + BAND_STEP;
    else return rp + {1'b0, l[LW-1:1]} + {{(AW-1){1'b0}}, l[0]};
  endfunction

  function automatic logic [AW-1:0] next_half(input logic [AW-1:0] ha, input logic [LW-1:0] l,
                                               input half_mode_e m);
    if (m == HM_BAND) return ha + BAND_STEP;
    else return ha + (l - SHORT_BIAS);
  endfunction
endpackage

// File: rtl/adpcm_tick_div.sv
module adpcm_tick_div #(
  parameter int PRESCALE = 6,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DMAX = {DIV_W{1'b1}};

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_top;

  assign div_top = DMAX - div_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_cnt == PW'(PRESCALE - 1)) begin
        pre_cnt <= '0;
        if (div_cnt >= div_top) begin
          div_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adpcm_play_core.sv
module adpcm_play_core
  import adpcm_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_we,
  input  logic [3:0]    cmd_flags,
  input  logic [AW-1:0] rd_ptr,
  input  logic [LW-1:0] play_len,
  input  logic          stop_req,
  input  logic          pause_req,
  input  logic          resume_req,
  input  logic [7:0]    mem_data,
  output logic [AW-1:0] ptr,
  output logic [LW-1:0] len_q,
  output logic [2:0]    mode_q,
  output logic [3:0]    code,
  output logic          code_vld,
  output logic          half_flag,
  output logic          full_flag,
  output logic          run,
  output logic          paused,
  output logic          byte_end,
  output logic          end_hit,
  output logic          half_hit
);
  // mode_q: [2] stop at end, [1] repeat, [0] hold length
  logic [LW-1:0] len_base;
  logic [AW-1:0] half_a;
  logic [AW-1:0] ptr_nx;
  logic          nib;
  logic          ctrl;
  logic          step;
  half_mode_e    hmode;

  assign ctrl     = cmd_we | stop_req | pause_req | resume_req;
  assign step     = tick & run & ~paused & ~ctrl;
  assign byte_end = step & nib;
  assign end_hit  = byte_end & (len_q == '0) & ~mode_q[0];
  assign ptr_nx   = ptr + 1'b1;
  assign hmode    = half_mode(len_base, mode_q[1]);
  assign half_hit = byte_end & ~end_hit &
                    ((hmode == HM_FIXED) ? (ptr_nx == '0 || ptr_nx == {1'b1, {(AW-1){1'b0}}})
                                         : (ptr_nx == half_a));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; len_q <= '0; len_base <= '0; half_a <= '0; mode_q <= '0;
      code <= '0; code_vld <= 1'b0; nib <= 1'b0;
      half_flag <= 1'b0; full_flag <= 1'b0; run <= 1'b0; paused <= 1'b0;
    end else begin
      code_vld <= step;
      if (step) begin
        code <= nib ? mem_data[3:0] : mem_data[7:4];
        nib  <= ~nib;
      end
      if (cmd_we) begin
        mode_q <= cmd_flags[2:0];
        if (cmd_flags[3]) begin
          half_flag <= 1'b0;
          full_flag <= 1'b0;
        end
        if (cmd_flags[2]) begin
          ptr       <= rd_ptr;
          len_q     <= play_len;
          len_base  <= play_len;
          half_a    <= first_half(rd_ptr, play_len);
          run       <= 1'b1;
          paused    <= 1'b0;
          nib       <= 1'b0;
          half_flag <= 1'b0;
          full_flag <= 1'b0;
        end
      end else if (stop_req) begin
        run         <= 1'b0;
        paused      <= 1'b0;
        mode_q[2:1] <= 2'b00;
      end else if (pause_req) begin
        if (run) begin
          paused      <= 1'b1;
          mode_q[2:1] <= 2'b00;
        end
      end else if (resume_req) begin
        paused <= 1'b0;
      end else if (end_hit) begin
        full_flag <= 1'b1;
        half_flag <= 1'b0;
        mode_q[1] <= 1'b0;
        if (mode_q[2]) begin
          run       <= 1'b0;
          mode_q[2] <= 1'b0;
        end
      end else if (byte_end) begin
        ptr <= ptr_nx;
        if (len_q != '0) len_q <= len_q - 1'b1;
        if (half_hit) begin
          half_flag <= 1'b1;
          full_flag <= 1'b0;
          if (hmode != HM_FIXED) half_a <= next_half(half_a, len_base, hmode);
        end
      end
    end
  end
endmodule

// File: rtl/adpcm_nibble_player.sv
module adpcm_nibble_player
  import adpcm_seq_pkg::*;
#(
  parameter int PRESCALE = 6,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             cmd_we,
  input  logic [3:0]       cmd_flags,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [LW-1:0]    play_len,
  input  logic             stop_req,
  input  logic             pause_req,
  input  logic             resume_req,
  output logic [AW-1:0]    mem_addr,
  input  logic [7:0]       mem_data,
  output logic [3:0]       code,
  output logic             code_vld,
  output logic             half_flag,
  output logic             full_flag,
  output logic             play_sts,
  output logic             stop_sts
);
  // named internal events, brought out for the checker
  logic          tick;
  logic          run;
  logic          paused;
  logic          byte_end;
  logic          end_hit;
  logic          half_hit;
  logic [2:0]    mode_q;
  logic [LW-1:0] len_q;

  adpcm_tick_div #(.PRESCALE(PRESCALE), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
  );

  adpcm_play_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_we(cmd_we), .cmd_flags(cmd_flags), .rd_ptr(rd_ptr), .play_len(play_len),
    .stop_req(stop_req), .pause_req(pause_req), .resume_req(resume_req),
    .mem_data(mem_data), .ptr(mem_addr), .len_q(len_q), .mode_q(mode_q),
    .code(code), .code_vld(code_vld), .half_flag(half_flag), .full_flag(full_flag),
    .run(run), .paused(paused), .byte_end(byte_end), .end_hit(end_hit), .half_hit(half_hit)
  );

  assign play_sts = run & ~paused;
  assign stop_sts = ~play_sts;
endmodule

// File: rtl/adpcm_nibble_player_chk.sv
module adpcm_nibble_player_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        cmd_we,
  input logic        stop_req,
  input logic        code_vld,
  input logic        play_sts,
  input logic        stop_sts,
  input logic        half_flag,
  input logic        full_flag,
  input logic        paused,
  input logic        byte_end,
  input logic        end_hit,
  input logic        half_hit,
  input logic [2:0]  mode_q,
  input logic [15:0] len_q,
  input logic [15:0] mem_addr
);
  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  p_vld_single_r11: assert property (@(posedge clk) disable iff (!rst_n) code_vld |=> !code_vld);
  p_vld_needs_play_r11: assert property (@(posedge clk) disable iff (!rst_n) code_vld |-> $past(play_sts));
  p_status_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) play_sts != stop_sts);
  p_end_full_r4: assert property (@(posedge clk) disable iff (!rst_n) end_hit |=> full_flag && !half_flag);
  p_end_stop_r4: assert property (@(posedge clk) disable iff (!rst_n) end_hit && mode_q[2] |=> stop_sts);
  p_len_floor_r5: assert property (@(posedge clk) disable iff (!rst_n) byte_end && len_q == 16'h0 |=> len_q == 16'h0);
  p_half_sets_r6: assert property (@(posedge clk) disable iff (!rst_n) half_hit |=> half_flag && !full_flag);
  p_stop_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !cmd_we |=> mode_q[2:1] == 2'b00 && stop_sts);
  p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) paused && !cmd_we |=> $stable(mem_addr));
endmodule

bind adpcm_nibble_player adpcm_nibble_player_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_we(cmd_we), .stop_req(stop_req),
  .code_vld(code_vld), .play_sts(play_sts), .stop_sts(stop_sts),
  .half_flag(half_flag), .full_flag(full_flag), .paused(paused),
  .byte_end(byte_end), .end_hit(end_hit), .half_hit(half_hit),
  .mode_q(mode_q), .len_q(len_q), .mem_addr(mem_addr)
);

// File: tb/adpcm_nibble_player_bench.sv
`timescale 1ns/1ps
module adpcm_nibble_player_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  div_sel = 4'd15;
  logic        cmd_we = 1'b0;
  logic [3:0]  cmd_flags = 4'd0;
  logic [15:0] rd_ptr = 16'd0;
  logic [15:0] play_len = 16'd0;
  logic        stop_req = 1'b0, pause_req = 1'b0, resume_req = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic [3:0]  code;
  logic        code_vld, half_flag, full_flag, play_sts, stop_sts;

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_data = memf(mem_addr);

  adpcm_nibble_player u_adpcm_nibble_player (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cmd_we(cmd_we), .cmd_flags(cmd_flags),
    .rd_ptr(rd_ptr), .play_len(play_len), .stop_req(stop_req), .pause_req(pause_req),
    .resume_req(resume_req), .mem_addr(mem_addr), .mem_data(mem_data), .code(code),
    .code_vld(code_vld), .half_flag(half_flag), .full_flag(full_flag),
    .play_sts(play_sts), .stop_sts(stop_sts)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, vld_count = 0, prev_vld_cyc = -1, last_gap = 0;
  bit prev_vld = 0, done = 0;
  // reference model
  bit [15:0] m_ptr, m_len, m_base, m_half;
  bit [2:0]  m_mode;
  bit        m_run = 0, m_paused = 0, m_nib = 0, m_hf = 0, m_ff = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit [15:0] ref_first(input bit [15:0] rp, input bit [15:0] l);
    int s;
    if (l >= 16'h8000 && l <= 16'h80FF) s = rp + 'h85;
    else s = rp + (int'(l) + 1) / 2;
    return s[15:0];
  endfunction

  task automatic ref_byte_done();
    bit band;
    if (m_len == 0 && !m_mode[0]) begin
      m_ff = 1; m_hf = 0; m_mode[1] = 0;
      if (m_mode[2]) begin m_run = 0; m_mode[2] = 0; end
    end else begin
      m_ptr = m_ptr + 1;
      if (m_len != 0) m_len = m_len - 1;
      band = (m_base >= 16'h8000 && m_base <= 16'h80FF);
      if (m_mode[1] && band) begin
        if (m_ptr == m_half) begin m_hf = 1; m_ff = 0; m_half = m_half + 16'h85; end
      end else if (m_base < 16'h7FFF) begin
        if (m_ptr == m_half) begin m_hf = 1; m_ff = 0; m_half = m_half + m_base - 16'd1024; end
      end else if (m_ptr == 16'h0000 || m_ptr == 16'h8000) begin
        m_hf = 1; m_ff = 0;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: cycles %0d expected below %0d", cyc, 180000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // monitor: every code event is compared with the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_vld && code_vld) chk(0, "R11 strobe longer than one clock", 1, 0);
      prev_vld = code_vld;
      if (code_vld) begin
        bit [7:0] b;
        vld_count++;
        if (prev_vld_cyc >= 0) last_gap = cyc - prev_vld_cyc;
        prev_vld_cyc = cyc;
        if (!m_run || m_paused) chk(0, "R11 code while not playing", 1, 0);
        b = memf(m_ptr);
        chk(code == (m_nib ? b[3:0] : b[7:4]), "R2 nibble order", code, m_nib ? b[3:0] : b[7:4]);
        if (m_nib) ref_byte_done();
        m_nib = ~m_nib;
        chk(mem_addr == m_ptr, "R2 pointer", mem_addr, m_ptr);
        chk(half_flag == m_hf, "R6 half flag", half_flag, m_hf);
        chk(full_flag == m_ff, "R4 full flag", full_flag, m_ff);
        chk(play_sts == (m_run && !m_paused), "R4 play status", play_sts, m_run && !m_paused);
      end
    end
  end

  task automatic do_cmd(input bit [3:0] f, input bit [15:0] rp, input bit [15:0] l);
    @(posedge clk); #1;
    cmd_flags = f; rd_ptr = rp; play_len = l; cmd_we = 1;
    @(posedge clk); #1;
    cmd_we = 0;
    m_mode = f[2:0];
    if (f[3]) begin m_hf = 0; m_ff = 0; end
    if (f[2]) begin
      m_ptr = rp; m_len = l; m_base = l; m_half = ref_first(rp, l);
      m_run = 1; m_paused = 0; m_nib = 0; m_hf = 0; m_ff = 0; prev_vld_cyc = -1;
    end
  endtask

  task automatic do_stop();
    @(posedge clk); #1; stop_req = 1;
    @(posedge clk); #1; stop_req = 0;
    m_run = 0; m_paused = 0; m_mode[2:1] = 0;
  endtask

  task automatic do_pause();
    @(posedge clk); #1; pause_req = 1;
    @(posedge clk); #1; pause_req = 0;
    if (m_run) begin m_paused = 1; m_mode[2:1] = 0; end
    prev_vld_cyc = -1;
  endtask

  task automatic do_resume();
    @(posedge clk); #1; resume_req = 1;
    @(posedge clk); #1; resume_req = 0;
    if (m_run) m_paused = 0;
  endtask

  task automatic wait_half(input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (half_flag) begin hit = 1; break; end
    end
  endtask

  task automatic wait_full(input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (full_flag) begin hit = 1; break; end
    end
  endtask

  task automatic wait_addr(input bit [15:0] a, input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (mem_addr == a) begin hit = 1; break; end
    end
  endtask

  initial begin
    bit hit;
    int v;
    bit [15:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(play_sts == 0 && stop_sts == 1, "R12 reset status", {play_sts, stop_sts}, 2'b01);
    chk(half_flag == 0 && full_flag == 0, "R12 reset flags", {half_flag, full_flag}, 0);
    chk(code_vld == 0 && mem_addr == 0, "R12 reset outputs", mem_addr, 0);

    // R11 / R3: ticks while stopped, write without start
    repeat (150) @(negedge clk);
    do_cmd(4'b0010, 16'h1234, 16'd5);
    repeat (150) @(negedge clk);
    chk(vld_count == 0, "R11 no codes while stopped", vld_count, 0);
    chk(play_sts == 0, "R3 write without start", play_sts, 0);

    // R1 R3 R4: period and normal end
    div_sel = 4'd13;
    do_cmd(4'b0100, 16'h0100, 16'd20);
    chk(play_sts == 1 && stop_sts == 0, "R3 start status", play_sts, 1);
    v = vld_count;
    while (vld_count < v + 6) @(negedge clk);
    chk(last_gap == 6 * (16 - 13), "R1 period D=13", last_gap, 18);
    wait_full(3000, hit);
    @(negedge clk);
    chk(hit && stop_sts, "R4 stop at end", {hit, stop_sts}, 2'b11);
    chk(!half_flag && mem_addr == 16'h0114, "R4 end pointer", mem_addr, 16'h0114);
    div_sel = 4'd10;
    do_cmd(4'b0100, 16'h0500, 16'd3);
    v = vld_count;
    while (vld_count < v + 4) @(negedge clk);
    chk(last_gap == 6 * (16 - 10), "R1 period D=10", last_gap, 36);
    do_stop();

    // R6 short buffer half points
    div_sel = 4'd15;
    do_cmd(4'b0100, 16'h2000, 16'h0500);
    wait_half(30000, hit);
    chk(hit && mem_addr == 16'h2280 && !full_flag, "R6 first half", mem_addr, 16'h2280);
    do_cmd(4'b1000, 16'h0, 16'h0);
    chk(!half_flag, "R12 acknowledge", half_flag, 0);
    wait_half(30000, hit);
    chk(hit && mem_addr == 16'h2380, "R6 second half", mem_addr, 16'h2380);
    do_stop();
    chk(stop_sts && !play_sts, "R9 stop", play_sts, 0);

    // R7 repeat window
    do_cmd(4'b0110, 16'h1000, 16'h8010);
    wait_half(10000, hit);
    chk(hit && mem_addr == 16'h1085, "R7 first half", mem_addr, 16'h1085);
    do_cmd(4'b1010, 16'h0, 16'h0);
    wait_half(10000, hit);
    chk(hit && mem_addr == 16'h110A, "R7 second half", mem_addr, 16'h110A);
    do_stop();

    // R8 fixed addresses
    do_cmd(4'b0100, 16'h7FF0, 16'h7FFF);
    wait_half(2000, hit);
    chk(hit && mem_addr == 16'h8000, "R8 half at 0x8000", mem_addr, 16'h8000);
    do_stop();

    // R5 hold length
    do_cmd(4'b0101, 16'h3000, 16'd2);
    wait_addr(16'h300A, 2000, hit);
    chk(hit && !full_flag && play_sts, "R5 no end with hold", {hit, full_flag, play_sts}, 3'b101);
    do_stop();

    // R10 R9 pause / resume
    div_sel = 4'd14;
    do_cmd(4'b0100, 16'h4000, 16'd6);
    wait_addr(16'h4002, 2000, hit);
    do_pause();
    chk(!play_sts && stop_sts, "R10 pause status", play_sts, 0);
    a = mem_addr; v = vld_count;
    repeat (300) @(negedge clk);
    chk(mem_addr == a && vld_count == v, "R10 paused holds", mem_addr, a);
    do_resume();
    chk(play_sts, "R10 resume status", play_sts, 1);
    wait_full(3000, hit);
    repeat (60) @(negedge clk);
    chk(hit && play_sts, "R9 start bit cleared by pause", {hit, play_sts}, 2'b11);
    do_stop();
    v = vld_count;
    do_resume();
    repeat (60) @(negedge clk);
    chk(!play_sts && vld_count == v, "R10 resume after stop ignored", play_sts, 0);

    // random traffic
    for (int it = 0; it < 12; it++) begin
      div_sel = 4'(12 + $urandom % 4);
      do_cmd({1'b0, 1'b1, 1'($urandom % 2), 1'($urandom % 2)}, 16'($urandom), 16'(2 + $urandom % 40));
      for (int k = 0; k < 8; k++) begin
        int act;
        repeat (5 + $urandom % 80) @(negedge clk);
        act = $urandom % 4;
        if (act == 0) do_pause();
        else if (act == 1) do_resume();
        else if (act == 2) do_cmd({1'b1, 1'b0, m_mode[1:0]}, 16'h0, 16'h0);
      end
      do_stop();
      repeat (30) @(negedge clk);
      chk(stop_sts && half_flag == m_hf && full_flag == m_ff, "R9 random end state", {half_flag, full_flag}, {m_hf, m_ff});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule